// File: doc/BRIEF.md
# Timer Channel Output-Compare Unit

This block is one output channel of a general-purpose timer. It holds its own reload counter, which counts up or down on the counter clock while enabled, and compares the freshly stepped count against a programmable compare value. A 3-bit mode input selects how the single channel level, the prepare output, reacts:
- hold its level on a match
- set or clear it on a match
- toggle it on a match
- force it low or high without regard to the count
- generate one of two complementary PWM levels that also depend on the counting direction

Each time the counter reloads, the block emits a one-cycle wrap pulse. Surrounding logic uses that pulse as the period event. Downstream logic, such as polarity, enable gating or dead-time, takes the prepare output as its input.

Top module: `tmr_oc_chan`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, prep_o and wrap_o are 0. The counter starts at 0.
- R2: The counter changes only on a clk_i edge where cnt_en_i is 1. While cnt_en_i is 0 the count holds and wrap_o stays 0.
- R3: Up-counting (dir_down_i=0): the counter steps count+1 until it reaches reload_i. On the next step it goes to 0. That step raises wrap_o for exactly that one cycle.
- R4: Down-counting (dir_down_i=1): the counter steps count-1 until it reaches 0. On the next step it loads reload_i. That step raises wrap_o for one cycle.
- R5: A match is an enabled step whose new count equals cmp_i. With mode_i=0, prep_o never changes.
- R6: With mode_i=1, a match sets prep_o to 1. With mode_i=2, a match clears prep_o to 0. Without a match, prep_o holds.
- R7: With mode_i=3, every match inverts prep_o. For reload 0x63 and compare 0x03, prep_o therefore changes exactly once per 100-step period.
- R8: mode_i=4 drives prep_o to 0 and mode_i=5 drives it to 1. Either takes effect on the next clk_i edge, even with cnt_en_i at 0 and no match.
- R9: With mode_i=6, prep_o is 1 when the new count is below cmp_i while counting up. While counting down it is 1 when the new count is at or below cmp_i. Otherwise prep_o is 0.
- R10: mode_i=7 gives exactly the inverse of the mode 6 level in every cycle.
- R11: A new mode_i value does not change prep_o before the next clk_i edge. It acts from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Counter enable |
| dir_down_i | input | 1 | 1 = count down, 0 = count up |
| reload_i | input | W | Auto-reload value |
| cmp_i | input | W | Channel compare value |
| mode_i | input | 3 | Output-compare mode (0..7) |
| prep_o | output | 1 | Channel output-prepare level |
| wrap_o | output | 1 | One-cycle reload/overflow pulse |

## Verification
The bench builds the channel with W=8 rather than the default 16. This keeps a full 0x00..0x63 period, and two complete toggle periods, within a few hundred cycles. The narrower width also makes short periods such as reload 9 cheap, so the PWM duty can be counted in both directions. A reference model derived from the requirements tracks count, level and wrap in every cycle. The enable-off and forced-mode scenarios check that a stopped counter still lets forced levels through.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;
  typedef enum logic [2:0] {
    OC_HOLD   = 3'd0,
    OC_SET    = 3'd1,
    OC_CLEAR  = 3'd2,
    OC_TOGGLE = 3'd3,
    OC_LOW    = 3'd4,
    OC_HIGH   = 3'd5,
    OC_PWM_A  = 3'd6,
    OC_PWM_B  = 3'd7
  } oc_mode_e;
endpackage

// File: rtl/tmr_oc_counter.sv
module tmr_oc_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         down_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_q_o,
  output logic [W-1:0] cnt_d_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] Zero = '0;
  localparam logic [W-1:0] One  = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap_d, wrap_q;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    if (en_i) begin
      if (down_i) begin
        wrap_d = (cnt_q == Zero);
        cnt_d  = wrap_d ? reload_i : cnt_q - One;
      end else begin
        // >= keeps a lowered reload from running the full range
        wrap_d = (cnt_q >= reload_i);
        cnt_d  = wrap_d ? Zero : cnt_q + One;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign cnt_q_o = cnt_q;
  assign cnt_d_o = cnt_d;
  assign wrap_o  = wrap_q;
endmodule

// File: rtl/tmr_oc_compare.sv
module tmr_oc_compare #(
  parameter int W = 16
) (
  input  logic         en_i,
  input  logic         down_i,
  input  logic [W-1:0] cnt_next_i,
  input  logic [W-1:0] cmp_i,
  output logic         match_o,
  output logic         pwm_lvl_o
);
  assign match_o   = en_i && (cnt_next_i == cmp_i);
  // Up: active below compare; down: active at or below compare
  assign pwm_lvl_o = down_i ? (cnt_next_i <= cmp_i) : (cnt_next_i < cmp_i);
endmodule

// File: rtl/tmr_oc_prep.sv
module tmr_oc_prep
  import tmr_oc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       match_i,
  input  logic       pwm_lvl_i,
  output logic       prep_o
);
  oc_mode_e mode;
  logic     prep_q, prep_d;

  assign mode = oc_mode_e'(mode_i);

  always_comb begin
    prep_d = prep_q;
    unique case (mode)
      OC_HOLD:   prep_d = prep_q;
      OC_SET:    if (match_i) prep_d = 1'b1;
      OC_CLEAR:  if (match_i) prep_d = 1'b0;
      OC_TOGGLE: if (match_i) prep_d = ~prep_q;
      OC_LOW:    prep_d = 1'b0;
      OC_HIGH:   prep_d = 1'b1;
      OC_PWM_A:  prep_d = pwm_lvl_i;
      OC_PWM_B:  prep_d = ~pwm_lvl_i;
      default:   prep_d = prep_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prep_q <= 1'b0;
    else         prep_q <= prep_d;
  end

  assign prep_o = prep_q;
endmodule

// File: rtl/tmr_oc_chan.sv
module tmr_oc_chan #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         dir_down_i,
  input  logic [W-1:0] reload_i,
  input  logic [W-1:0] cmp_i,
  input  logic [2:0]   mode_i,
  output logic         prep_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         match, pwm_lvl;

  tmr_oc_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cnt_en_i),
    .down_i   (dir_down_i),
    .reload_i (reload_i),
    .cnt_q_o  (cnt_q),
    .cnt_d_o  (cnt_d),
    .wrap_o   (wrap_o)
  );

  tmr_oc_compare #(.W(W)) u_cmp (
    .en_i       (cnt_en_i),
    .down_i     (dir_down_i),
    .cnt_next_i (cnt_d),
    .cmp_i      (cmp_i),
    .match_o    (match),
    .pwm_lvl_o  (pwm_lvl)
  );

  tmr_oc_prep u_prep (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .match_i   (match),
    .pwm_lvl_i (pwm_lvl),
    .prep_o    (prep_o)
  );
endmodule

// File: rtl/tmr_oc_chk.sv
module tmr_oc_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cnt_en_i,
  input logic         dir_down_i,
  input logic [W-1:0] reload_i,
  input logic [2:0]   mode_i,
  input logic [W-1:0] cnt_q,
  input logic         match,
  input logic         prep_o,
  input logic         wrap_o
);
  assert_hold_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> ($stable(cnt_q) && !wrap_o));

  assert_wrap_needs_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> $past(cnt_en_i));

  assert_up_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !dir_down_i && cnt_q == reload_i) |=> (cnt_q == '0 && wrap_o));

  assert_down_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && dir_down_i && cnt_q == '0) |=> (cnt_q == $past(reload_i) && wrap_o));

  assert_hold_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0) |=> $stable(prep_o));

  assert_set_on_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd1 && match) |=> prep_o);

  assert_clear_on_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd2 && match) |=> !prep_o);

  assert_toggle_on_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd3 && match) |=> (prep_o != $past(prep_o)));

  assert_force_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd4) |=> !prep_o);

  assert_force_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd5) |=> prep_o);
endmodule

bind tmr_oc_chan tmr_oc_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_en_i   (cnt_en_i),
  .dir_down_i (dir_down_i),
  .reload_i   (reload_i),
  .mode_i     (mode_i),
  .cnt_q      (cnt_q),
  .match      (match),
  .prep_o     (prep_o),
  .wrap_o     (wrap_o)
);

// File: tb/sim_tmr_oc_chan.sv
`timescale 1ns/1ps
module sim_tmr_oc_chan;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cnt_en_i = 1'b0;
  logic         dir_down_i = 1'b0;
  logic [W-1:0] reload_i = '0;
  logic [W-1:0] cmp_i = '0;
  logic [2:0]   mode_i = 3'd0;
  logic         prep_o, wrap_o;

  int checks = 0;
  int fails = 0;

  // reference model state
  logic [W-1:0] m_cnt = '0;
  logic         m_prep = 1'b0;
  logic         m_wrap = 1'b0;

  always #2.5 clk = ~clk;

  tmr_oc_chan #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i), .dir_down_i(dir_down_i),
    .reload_i(reload_i), .cmp_i(cmp_i), .mode_i(mode_i),
    .prep_o(prep_o), .wrap_o(wrap_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: update model from requirements, sample 1 ns after the edge
  task automatic tick();
    logic [W-1:0] nc;
    logic w, hit, pwm;
    nc = m_cnt; w = 1'b0;
    if (cnt_en_i) begin
      if (dir_down_i) begin w = (m_cnt == 0); nc = w ? reload_i : m_cnt - 1'b1; end
      else begin w = (m_cnt >= reload_i); nc = w ? '0 : m_cnt + 1'b1; end
    end
    hit = cnt_en_i && (nc == cmp_i);
    pwm = dir_down_i ? (nc <= cmp_i) : (nc < cmp_i);
    case (mode_i)
      3'd1: if (hit) m_prep = 1'b1;
      3'd2: if (hit) m_prep = 1'b0;
      3'd3: if (hit) m_prep = ~m_prep;
      3'd4: m_prep = 1'b0;
      3'd5: m_prep = 1'b1;
      3'd6: m_prep = pwm;
      3'd7: m_prep = ~pwm;
      default: ;
    endcase
    m_cnt = nc; m_wrap = w;
    @(posedge clk); #1;
  endtask

  task automatic tick_cmp(input string tag);
    tick();
    chk(prep_o == m_prep, {tag, " prep"}, prep_o, m_prep);
    chk(wrap_o == m_wrap, {tag, " wrap"}, wrap_o, m_wrap);
  endtask

  task automatic t_reset();
    chk(prep_o == 1'b0, "R1 prep in reset", prep_o, 0);
    chk(wrap_o == 1'b0, "R1 wrap in reset", wrap_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    tick();
    chk(prep_o == 1'b0 && wrap_o == 1'b0, "R1 first cycle", {prep_o, wrap_o}, 0);
  endtask

  task automatic t_toggle_period();
    int edges = 0, wraps = 0;
    logic last;
    reload_i = 8'h63; cmp_i = 8'h03; mode_i = 3'd3; dir_down_i = 1'b0; cnt_en_i = 1'b1;
    last = prep_o;
    for (int i = 0; i < 200; i++) begin
      tick_cmp("R7");
      if (prep_o != last) edges++;
      if (wrap_o) wraps++;
      last = prep_o;
    end
    chk(edges == 2, "R7 toggles in two periods", edges, 2);
    chk(wraps == 2, "R3 wraps in two periods", wraps, 2);
  endtask

  task automatic t_up_wrap();
    int wraps = 0;
    reload_i = 8'd9; cmp_i = 8'd200; mode_i = 3'd0; dir_down_i = 1'b0; cnt_en_i = 1'b1;
    for (int i = 0; i < 30; i++) begin
      tick_cmp("R3");
      if (wrap_o) wraps++;
    end
    chk(wraps == 3, "R3 one wrap per 10 steps", wraps, 3);
  endtask

  task automatic t_hold();
    logic start;
    reload_i = 8'd9; cmp_i = 8'd4; mode_i = 3'd0; cnt_en_i = 1'b1;
    start = prep_o;
    for (int i = 0; i < 25; i++) begin
      tick_cmp("R5");
      chk(prep_o == start, "R5 level held", prep_o, start);
    end
  endtask

  task automatic t_set_clear();
    reload_i = 8'd9; cmp_i = 8'd5; cnt_en_i = 1'b1; dir_down_i = 1'b0;
    mode_i = 3'd1;
    for (int i = 0; i < 12; i++) tick_cmp("R6 set");
    chk(prep_o == 1'b1, "R6 set after match", prep_o, 1);
    mode_i = 3'd2;
    for (int i = 0; i < 12; i++) tick_cmp("R6 clear");
    chk(prep_o == 1'b0, "R6 cleared after match", prep_o, 0);
  endtask

  task automatic t_forced();
    cnt_en_i = 1'b0; cmp_i = 8'd250;
    mode_i = 3'd5;
    tick_cmp("R8 high");
    chk(prep_o == 1'b1, "R8 forced high", prep_o, 1);
    mode_i = 3'd4;
    tick_cmp("R8 low");
    chk(prep_o == 1'b0, "R8 forced low", prep_o, 0);
  endtask

  task automatic t_enable_off();
    logic lvl;
    reload_i = 8'd9; cmp_i = 8'd4; mode_i = 3'd6; dir_down_i = 1'b0; cnt_en_i = 1'b1;
    for (int i = 0; i < 7; i++) tick_cmp("R2 run");
    cnt_en_i = 1'b0;
    tick_cmp("R2 stop");
    lvl = prep_o;
    for (int i = 0; i < 20; i++) begin
      tick_cmp("R2 frozen");
      chk(prep_o == lvl && !wrap_o, "R2 no activity", {prep_o, wrap_o}, {lvl, 1'b0});
    end
  endtask

  task automatic t_pwm();
    int hi;
    reload_i = 8'd9; cmp_i = 8'd4; mode_i = 3'd6; dir_down_i = 1'b0; cnt_en_i = 1'b1;
    for (int i = 0; i < 10; i++) tick_cmp("R9 settle");
    hi = 0;
    for (int i = 0; i < 10; i++) begin tick_cmp("R9 up"); hi += prep_o; end
    chk(hi == 4, "R9 up duty", hi, 4);
    dir_down_i = 1'b1;
    for (int i = 0; i < 10; i++) tick_cmp("R9 settle dn");
    hi = 0;
    for (int i = 0; i < 10; i++) begin tick_cmp("R9 down"); hi += prep_o; end
    chk(hi == 5, "R9 down duty", hi, 5);
    mode_i = 3'd7;
    hi = 0;
    for (int i = 0; i < 10; i++) begin tick_cmp("R10 down"); hi += prep_o; end
    chk(hi == 5, "R10 inverse down duty", hi, 5);
    dir_down_i = 1'b0;
    for (int i = 0; i < 10; i++) tick_cmp("R10 settle");
    hi = 0;
    for (int i = 0; i < 10; i++) begin tick_cmp("R10 up"); hi += prep_o; end
    chk(hi == 6, "R10 inverse up duty", hi, 6);
  endtask

  task automatic t_down();
    int wraps = 0;
    reload_i = 8'd7; cmp_i = 8'd3; mode_i = 3'd3; dir_down_i = 1'b1; cnt_en_i = 1'b1;
    for (int i = 0; i < 32; i++) begin
      tick_cmp("R4");
      if (wrap_o) wraps++;
    end
    chk(wraps >= 3, "R4 down reloads seen", wraps, 4);
  endtask

  task automatic t_mode_switch();
    cnt_en_i = 1'b0;
    mode_i = 3'd4; tick_cmp("R11 prep");
    @(negedge clk); mode_i = 3'd5; #1;
    chk(prep_o == 1'b0, "R11 before edge", prep_o, 0);
    @(posedge clk); #1; m_prep = 1'b1;
    chk(prep_o == 1'b1, "R11 after edge", prep_o, 1);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #12;
    t_reset();
    t_toggle_period();
    t_up_wrap();
    t_hold();
    t_set_clear();
    t_forced();
    t_enable_off();
    t_pwm();
    t_down();
    t_mode_switch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule